// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Redirect Flush Controller

This block is the hazard control for the decode stage of a five-stage in-order pipeline. It watches the instruction word sitting in the fetch/decode register and a small record of whether the instruction that just moved into execute is a load, and which register that load writes. When the decoded instruction names the load's destination in either source field, the controller freezes the program counter and the fetch/decode register for one cycle. In that same cycle it tells the datapath to zero the control fields entering the decode/execute register, so that a no-op follows the load down the pipe. The load and everything older keep moving, and after the single bubble the forwarding path supplies the value.

The same controller also squashes the instruction fetched behind a redirect. When decode reports a jump, or a branch whose comparison in decode comes out taken, the controller raises a fetch flush that turns the word written into the fetch/decode register into zero. An all-zero word counts as a no-op everywhere. If a redirect shows up while decode is stalled, the flush is held back. It is issued in the following cycle, when the held branch or jump is free to leave decode.

The controller keeps its own copy of the execute-stage load flag and destination field, so the one-cycle length of the stall follows from its own state. Source fields sit at bits 25:21 and 20:16 of the word, and the load destination is the 20:16 field.

Top module: `ldh_ctl`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, no stall is signalled: pc_we_o=1, ifid_we_o=1, idex_zero_o=0. This holds even if a load was advancing when reset was applied.
- R2: A stall happens when the previous advancing decode instruction was a load (nonzero word with id_is_load_i=1) and its destination field (bits 20:16) equals bits 25:21 of the current decode word.
- R3: A stall also happens when that load destination equals bits 20:16 of the current decode word.
- R4: In a stall cycle, pc_we_o=0, ifid_we_o=0 and idex_zero_o=1 all hold together. Outside a stall, pc_we_o=1, ifid_we_o=1 and idex_zero_o=0.
- R5: A stall lasts exactly one cycle. The held instruction does not stall a second time.
- R6: No stall occurs when the previous decode instruction was not a load, even if the registers match, or when the load destination matches neither source field.
- R7: An all-zero decode word never stalls. An all-zero word flagged as a load is not recorded as a load, so the next instruction does not stall on register 0.
- R8: A jump in decode with no stall asserts if_flush_o for that cycle, and the write enables stay high.
- R9: A taken branch in decode with no stall asserts if_flush_o. A branch that is not taken does not.
- R10: When a stall and a redirect coincide, if_flush_o stays low in the stall cycle. It is asserted in the next cycle, while the held jump or branch is still in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_word_i | input | 32 | Instruction word in the fetch/decode register |
| id_is_load_i | input | 1 | Decoder flag: decode instruction reads data memory |
| id_jump_i | input | 1 | Decoder flag: decode instruction is an unconditional jump |
| id_br_taken_i | input | 1 | Decode-stage branch compare result: branch taken |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_zero_o | output | 1 | Select zeros for control fields entering decode/execute |
| if_flush_o | output | 1 | Zero the instruction written into fetch/decode |

## Verification
The load-use stall and the redirect flush can be requested in the same cycle. This happens when a branch or jump in decode reads the register that the load just ahead of it writes. The bench creates the case by placing a load directly before a taken branch, and again before a jump, with a matching source field. It then holds the branch or jump word in decode for a second cycle, as a frozen fetch/decode register would. The pass condition is a stall with no flush in the first cycle, followed by a flush with no stall in the second.

// File: rtl/ldh_pkg.sv
package ldh_pkg;

  // Bundle of pipeline control strobes produced by the controller.
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic idex_zero;
    logic if_flush;
  } ldh_ctl_t;

endpackage

// File: rtl/ldh_rst_sync.sv
module ldh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ldh_src_cmp.sv
module ldh_src_cmp #(
  parameter int WORD_W = 32,
  parameter int REG_AW = 5,
  parameter int RS_LSB = 21,
  parameter int RT_LSB = 16,
  parameter int NSRC   = 2
) (
  input  logic [WORD_W-1:0] id_word,
  input  logic              ex_memrd,
  input  logic [REG_AW-1:0] ex_rt,
  output logic              hit
);

  logic [NSRC-1:0] match;
  logic            word_live;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    localparam int FLSB = (gi == 0) ? RS_LSB : RT_LSB;
    assign match[gi] = (id_word[FLSB +: REG_AW] == ex_rt);
  end

  assign word_live = |id_word;
  assign hit       = ex_memrd & word_live & (|match);

  // R7: a zero decode word never produces a hazard
  always_comb begin
    a_r7_zero_no_hit: assert (!(id_word == '0 && hit));
  end

endmodule

// File: rtl/ldh_ex_track.sv
module ldh_ex_track #(
  parameter int WORD_W = 32,
  parameter int REG_AW = 5,
  parameter int RT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [WORD_W-1:0] id_word,
  input  logic              id_is_load,
  output logic              ex_memrd,
  output logic [REG_AW-1:0] ex_rt
);

  logic              memrd_d;
  logic [REG_AW-1:0] rt_d;
  logic              rt_en;

  // Next state: bubble clears the load flag; otherwise capture decode.
  always_comb begin
    rt_en   = !stall;
    memrd_d = stall ? 1'b0 : (id_is_load & (|id_word));
    rt_d    = id_word[RT_LSB +: REG_AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_memrd <= 1'b0;
      ex_rt    <= '0;
    end else begin
      ex_memrd <= memrd_d;
      if (rt_en) ex_rt <= rt_d;
    end
  end

  // R5: the cycle after a stall has no load recorded in execute
  a_r5_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_memrd);

  // R7: a zero word flagged as a load is not recorded
  a_r7_zero_not_load: assert property (@(posedge clk) disable iff (!rst_n)
    (id_word == '0) |=> !ex_memrd);

endmodule

// File: rtl/ldh_redirect.sv
module ldh_redirect (
  input  logic jump,
  input  logic br_taken,
  input  logic stall,
  output logic flush
);

  logic redirect_req;

  assign redirect_req = jump | br_taken;
  assign flush        = redirect_req & !stall;

  // R10: no flush while decode is held
  always_comb begin
    a_r10_hold_no_flush: assert (!(stall && flush));
  end

endmodule

// File: rtl/ldh_ctl.sv
module ldh_ctl #(
  parameter int WORD_W = 32,
  parameter int REG_AW = 5,
  parameter int RS_LSB = 21,
  parameter int RT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] id_word_i,
  input  logic              id_is_load_i,
  input  logic              id_jump_i,
  input  logic              id_br_taken_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_zero_o,
  output logic              if_flush_o
);

  import ldh_pkg::*;

  localparam int NSRC = 2;

  logic              rst_sync_n;
  logic              ex_memrd;
  logic [REG_AW-1:0] ex_rt;
  logic              stall;
  logic              flush;
  ldh_ctl_t          ctl;

  ldh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ldh_ex_track #(
    .WORD_W (WORD_W),
    .REG_AW (REG_AW),
    .RT_LSB (RT_LSB)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stall      (stall),
    .id_word    (id_word_i),
    .id_is_load (id_is_load_i),
    .ex_memrd   (ex_memrd),
    .ex_rt      (ex_rt)
  );

  ldh_src_cmp #(
    .WORD_W (WORD_W),
    .REG_AW (REG_AW),
    .RS_LSB (RS_LSB),
    .RT_LSB (RT_LSB),
    .NSRC   (NSRC)
  ) u_cmp (
    .id_word  (id_word_i),
    .ex_memrd (ex_memrd),
    .ex_rt    (ex_rt),
    .hit      (stall)
  );

  ldh_redirect u_redir (
    .jump     (id_jump_i),
    .br_taken (id_br_taken_i),
    .stall    (stall),
    .flush    (flush)
  );

  always_comb begin
    ctl.pc_we     = !stall;
    ctl.ifid_we   = !stall;
    ctl.idex_zero = stall;
    ctl.if_flush  = flush;
  end

  assign pc_we_o     = ctl.pc_we;
  assign ifid_we_o   = ctl.ifid_we;
  assign idex_zero_o = ctl.idex_zero;
  assign if_flush_o  = ctl.if_flush;

  // R4: the hold and the bubble travel together
  a_r4_hold_with_bubble: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pc_we_o |-> (!ifid_we_o && idex_zero_o));

  // R5: never two bubbles in a row
  a_r5_single_bubble: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idex_zero_o |=> !idex_zero_o);

  // R8 / R9: an unblocked redirect always flushes
  a_r8_redirect_flushes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((id_jump_i || id_br_taken_i) && pc_we_o) |-> if_flush_o);

  // R1: reset phase shows no stall
  always_comb begin
    a_r1_reset_idle: assert (rst_sync_n || (pc_we_o && !idex_zero_o));
  end

endmodule

// File: tb/ldh_ctl_tb.sv
module ldh_ctl_tb;

  typedef struct {
    logic  stall;
    logic  flush;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_word = '0;
  logic        id_is_load = 1'b0;
  logic        id_jump = 1'b0;
  logic        id_br_taken = 1'b0;
  logic        pc_we, ifid_we, idex_zero, if_flush;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ldh_ctl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_word_i     (id_word),
    .id_is_load_i  (id_is_load),
    .id_jump_i     (id_jump),
    .id_br_taken_i (id_br_taken),
    .pc_we_o       (pc_we),
    .ifid_we_o     (ifid_we),
    .idex_zero_o   (idex_zero),
    .if_flush_o    (if_flush)
  );

  function automatic logic [31:0] alu_w(input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, 16'h0001};
  endfunction

  function automatic logic [31:0] ld_w(input logic [4:0] rs, input logic [4:0] rt);
    return {6'h23, rs, rt, 16'h0004};
  endfunction

  // Driver: apply one decode cycle and queue its expected strobes.
  task automatic step(input logic [31:0] w, input logic ld, input logic j,
                      input logic bt, input logic es, input logic ef,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    id_word     = w;
    id_is_load  = ld;
    id_jump     = j;
    id_br_taken = bt;
    e.stall = es;
    e.flush = ef;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    wait (exp_q.size() == 0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    id_word = '0; id_is_load = 1'b0; id_jump = 1'b0; id_br_taken = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  // Monitor: compare at the falling edge, between driver updates.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        logic [3:0] act, want;
        e = exp_q.pop_front();
        act  = {pc_we, ifid_we, idex_zero, if_flush};
        want = {!e.stall, !e.stall, e.stall, e.flush};
        n_vec++;
        if (act !== want) begin
          n_bad++;
          $display("FAIL %s: {pc_we,ifid_we,zero,flush} actual=%b expected=%b",
                   e.tag, act, want);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    step(alu_w(1, 2), 0, 0, 0, 0, 0, "R1 idle after reset");
    step(ld_w(1, 5),  1, 0, 0, 0, 0, "R6 load after non-load");
    step(alu_w(5, 7), 0, 0, 0, 1, 0, "R2 rs matches load dest");
    step(alu_w(5, 7), 0, 0, 0, 0, 0, "R5 held instr no repeat");
    step(ld_w(2, 6),  1, 0, 0, 0, 0, "R6 load no prior load");
    step(alu_w(3, 6), 0, 0, 0, 1, 0, "R3 rt matches load dest");
    step(alu_w(3, 6), 0, 0, 0, 0, 0, "R5 released after one");
    step(ld_w(2, 8),  1, 0, 0, 0, 0, "R6 load");
    step(alu_w(9, 10), 0, 0, 0, 0, 0, "R6 no field match");
    step(alu_w(2, 11), 0, 0, 0, 0, 0, "R6 non-load producer");
    step(alu_w(11, 3), 0, 0, 0, 0, 0, "R6 match but not load");
    step(ld_w(1, 0),  1, 0, 0, 0, 0, "R7 load to reg0");
    step(32'h0,       0, 0, 0, 0, 0, "R7 zero word after load");
    step(32'h0,       1, 0, 0, 0, 0, "R7 zero word flagged load");
    step(alu_w(0, 0), 0, 0, 0, 0, 0, "R7 zero word not recorded");
    step(alu_w(1, 2), 0, 1, 0, 0, 1, "R8 jump flushes");
    step(32'h0,       0, 0, 0, 0, 0, "R8 flushed slot idle");
    step(alu_w(1, 2), 0, 0, 1, 0, 1, "R9 taken branch flushes");
    step(alu_w(1, 2), 0, 0, 0, 0, 0, "R9 untaken no flush");
    step(ld_w(1, 4),  1, 0, 0, 0, 0, "R10 load before branch");
    step(alu_w(4, 1), 0, 0, 1, 1, 0, "R10 stall defers flush");
    step(alu_w(4, 1), 0, 0, 1, 0, 1, "R10 flush after stall");
    step(ld_w(3, 7),  1, 0, 0, 0, 0, "R10 load before jump");
    step(alu_w(7, 0), 0, 1, 0, 1, 0, "R10 jump stall no flush");
    step(alu_w(7, 0), 0, 1, 0, 0, 1, "R10 jump flush next");
    step(ld_w(1, 9),  1, 0, 0, 0, 0, "R1 load before reset");
    do_reset();
    step(alu_w(9, 9), 0, 0, 0, 0, 0, "R1 reset clears load");
    step(alu_w(9, 9), 0, 0, 0, 0, 0, "R4 enables high no stall");

    wait (exp_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule